// File: doc/BRIEF.md
# Converter Register-Access SPI Sequencer

This block sits on the host side of a serial sigma-delta converter and turns short requests into complete register transactions on a mode-3 SPI link. In mode 3 the serial clock idles high, data is launched on the falling edge and captured on the rising edge. The block serves four requests. It can write the clock-control register or the setup register. It can send a 32-bit run of ones that resynchronises the converter's serial port. It can also read one 16-bit conversion result. Every register access is a command byte followed by a data phase, and all bits travel most-significant first. The block builds the command byte itself from the register index, the direction and the channel.

A conversion read does not start until the converter's active-low data-ready line is low. The block synchronises that line internally. The length of each clock phase and the delay from chip-select assertion to the first clock edge are parameters counted in system clocks. Chip select is released, and held high for a gap, after every transaction, so each access starts with a resynchronised link. A one-cycle pulse marks the result of a read, and the request port holds off new work by deasserting ready while a transaction is in flight.

Top module: `adc_spi_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, `cs_n` and `sclk` are 1, `req_ready` is 1 and `rd_done` is 0.
- R2: While `cs_n` is low, every low phase of `sclk`, and every high phase that ends in a falling edge (other than the chip-select setup phase), lasts exactly HALF_CYC system clocks.
- R3: The first falling edge of `sclk` comes at least CS_SETUP_CYC system clocks after `cs_n` falls.
- R4: Operation code 0 (clock write) sends 16 bits MSB first: the command byte 0x20 OR channel, then `req_arg` unchanged.
- R5: Operation code 1 (setup write) sends the command byte 0x10 OR channel, then a setup byte. In the setup byte, bits 7:6 are 01 when `req_arg[6]` is 1 (self-calibration) and 00 otherwise. Bits 5:3 carry the gain from `req_arg[5:3]`, and bits 2:0 carry the flags from `req_arg[2:0]`. `req_arg[7]` has no effect.
- R6: Operation code 2 (resync) sends 32 bits, all of them 1, within one chip-select window.
- R7: Operation code 3 (read) lowers `cs_n` only after `drdy_n` is seen low. It then sends the command byte 0x38 OR channel, followed by 16 zero bits. The 16 bits captured from `miso` during that data phase, MSB first, appear on `rd_data`.
- R8: `rd_done` is a single-cycle pulse, given only for reads, in the cycle after the rising edge that captures the last bit. `rd_data` holds the result in that cycle.
- R9: `req_ready` is low from the accepting cycle until the block returns to idle. A request held while the block is busy starts no transaction.
- R10: `sclk` is high whenever `cs_n` is high. Between two transactions `cs_n` stays high for at least HALF_CYC system clocks.
- R11: The number of rising `sclk` edges in one chip-select window is 16, 16, 32 and 24 for operation codes 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 2 | Operation: 0 clock write, 1 setup write, 2 resync, 3 read |
| req_chan | input | 1 | Converter input channel |
| req_arg | input | 8 | Clock byte, or calibration/gain/flags for a setup write |
| drdy_n | input | 1 | Converter data-ready, active low |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Chip select, active low |
| rd_data | output | 16 | Last conversion result |
| rd_done | output | 1 | One-cycle pulse when `rd_data` is new |

## Verification
The assertions check the link timing on every cycle: the clock stays high outside chip select, low phases meet the minimum length, the chip-select setup delay is honoured, a read only starts once data-ready is low, a resync keeps the data line at 1, ready drops on acceptance, and the done pulse is single-cycle and only follows reads. The bench sweeps channels, gains, calibration settings, flag bits and several read words. Only those scenarios show that the serial stream carries the right command and data bytes in the right order, that captured data reassembles correctly, that edge counts match each operation, and that a request held while busy is dropped.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int FRAME_W = 32;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    OP_CLKCFG = 2'd0,
    OP_SETUP  = 2'd1,
    OP_RESYNC = 2'd2,
    OP_READ   = 2'd3
  } seq_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_SETUP, S_LOW, S_HIGH, S_HOLD, S_GAP
  } seq_state_e;

  localparam logic [2:0] REG_SETUP = 3'd1;
  localparam logic [2:0] REG_CLOCK = 3'd2;
  localparam logic [2:0] REG_DATA  = 3'd3;

  // Command byte: bit7 zero, bits 6:4 register, bit3 read, bit2 standby, bits 1:0 channel
  function automatic logic [7:0] cmd_byte(logic [2:0] reg_idx, logic is_rd, logic chan);
    return {1'b0, reg_idx, is_rd, 1'b0, 1'b0, chan};
  endfunction

  // Setup byte: mode in 7:6 (01 = self-calibration), gain in 5:3, flags in 2:0
  function automatic logic [7:0] setup_byte(logic [7:0] arg);
    return {1'b0, arg[6], arg[5:3], arg[2:0]};
  endfunction

  function automatic logic [LEN_W-1:0] reg_width(logic [2:0] reg_idx);
    case (reg_idx)
      3'd3:       return LEN_W'(16);
      3'd6, 3'd7: return LEN_W'(24);
      default:    return LEN_W'(8);
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(seq_op_e op);
    case (op)
      OP_CLKCFG: return LEN_W'(8) + reg_width(REG_CLOCK);
      OP_SETUP:  return LEN_W'(8) + reg_width(REG_SETUP);
      OP_RESYNC: return LEN_W'(FRAME_W);
      default:   return LEN_W'(8) + reg_width(REG_DATA);
    endcase
  endfunction

  // Outgoing frame, left aligned in FRAME_W bits
  function automatic logic [FRAME_W-1:0] frame_bits(seq_op_e op, logic chan, logic [7:0] arg);
    case (op)
      OP_CLKCFG: return {cmd_byte(REG_CLOCK, 1'b0, chan), arg, 16'h0000};
      OP_SETUP:  return {cmd_byte(REG_SETUP, 1'b0, chan), setup_byte(arg), 16'h0000};
      OP_RESYNC: return '1;
      default:   return {cmd_byte(REG_DATA, 1'b1, chan), 24'h000000};
    endcase
  endfunction

endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= len - W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter #(
  parameter int TXW = 32,
  parameter int RXW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [TXW-1:0] load_val,
  input  logic           shift_tx,
  input  logic           shift_rx,
  input  logic           rx_bit,
  output logic           tx_msb,
  output logic [RXW-1:0] rx_word
);
  logic [TXW-1:0] tx_q;
  logic [RXW-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_q <= '1;
    else if (load)     tx_q <= load_val;
    else if (shift_tx) tx_q <= {tx_q[TXW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_q <= '0;
    else if (shift_rx) rx_q <= {rx_q[RXW-2:0], rx_bit};
  end

  assign tx_msb  = tx_q[TXW-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/adc_spi_sequencer.sv
module adc_spi_sequencer
  import adcseq_pkg::*;
#(
  parameter int HALF_CYC     = 10,
  parameter int CS_SETUP_CYC = 12,
  parameter int SYNC_STAGES  = 2,
  parameter int RD_W         = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic            req_chan,
  input  logic [7:0]      req_arg,
  input  logic            drdy_n,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            cs_n,
  output logic [RD_W-1:0] rd_data,
  output logic            rd_done
);
  localparam int TMAX = (HALF_CYC > CS_SETUP_CYC) ? HALF_CYC : CS_SETUP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] HALF_T  = TW'(HALF_CYC);
  localparam logic [TW-1:0] SETUP_T = TW'(CS_SETUP_CYC);

  seq_state_e state_q, state_d;
  seq_op_e    op_q;
  logic [LEN_W-1:0] bits_q;
  logic       rd_done_q;

  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_len;

  // named internal events
  logic accept, ev_rise, ev_fall, ev_last;
  logic drdy_s, op_is_read, op_is_resync;
  logic tx_msb;

  // data-ready synchroniser, depth chosen by parameter
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b1;
        else        s_q <= drdy_n;
      end
      assign drdy_s = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= {s_q[SYNC_STAGES-2:0], drdy_n};
      end
      assign drdy_s = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = HALF_T;
    accept   = 1'b0;
    ev_rise  = 1'b0;
    ev_fall  = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        accept = 1'b1;
        if (seq_op_e'(req_op) == OP_READ) begin
          state_d = S_WAIT;
        end else begin
          state_d  = S_SETUP;
          tmr_load = 1'b1;
          tmr_len  = SETUP_T;
        end
      end
      S_WAIT: if (!drdy_s) begin
        state_d  = S_SETUP;
        tmr_load = 1'b1;
        tmr_len  = SETUP_T;
      end
      S_SETUP: if (tmr_exp) begin
        state_d  = S_LOW;
        tmr_load = 1'b1;
      end
      S_LOW: if (tmr_exp) begin
        state_d  = S_HIGH;
        tmr_load = 1'b1;
        ev_rise  = 1'b1;
      end
      S_HIGH: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (bits_q == '0) begin
          state_d = S_HOLD;
        end else begin
          state_d = S_LOW;
          ev_fall = 1'b1;
        end
      end
      S_HOLD: if (tmr_exp) begin
        state_d  = S_GAP;
        tmr_load = 1'b1;
      end
      S_GAP: if (tmr_exp) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign ev_last      = ev_rise && (bits_q == LEN_W'(1));
  assign op_is_read   = (op_q == OP_READ);
  assign op_is_resync = (op_q == OP_RESYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      op_q      <= OP_CLKCFG;
      bits_q    <= '0;
      rd_done_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_done_q <= ev_last && op_is_read;
      if (accept) begin
        op_q   <= seq_op_e'(req_op);
        bits_q <= frame_len(seq_op_e'(req_op));
      end else if (ev_rise) begin
        bits_q <= bits_q - LEN_W'(1);
      end
    end
  end

  adcseq_timer #(.W(TW)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_exp)
  );

  adcseq_shifter #(.TXW(FRAME_W), .RXW(RD_W)) shf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (frame_bits(seq_op_e'(req_op), req_chan, req_arg)),
    .shift_tx (ev_fall),
    .shift_rx (ev_rise),
    .rx_bit   (miso),
    .tx_msb   (tx_msb),
    .rx_word  (rd_data)
  );

  assign cs_n      = (state_q == S_IDLE) || (state_q == S_WAIT) || (state_q == S_GAP);
  assign sclk      = (state_q != S_LOW);
  assign mosi      = cs_n ? 1'b1 : tx_msb;
  assign req_ready = (state_q == S_IDLE);
  assign rd_done   = rd_done_q;
endmodule

// File: rtl/adc_spi_sequencer_chk.sv
module adc_spi_sequencer_chk #(
  parameter int HALF_CYC     = 10,
  parameter int CS_SETUP_CYC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic req_valid,
  input logic req_ready,
  input logic rd_done,
  input logic drdy_s,
  input logic is_rd,
  input logic is_rsync
);
  localparam logic [15:0] HALF16  = 16'(HALF_CYC);
  localparam logic [15:0] SETUP16 = 16'(CS_SETUP_CYC);

  logic [15:0] low_run, cs_run;
  logic        seen_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run   <= '0;
      cs_run    <= '0;
      seen_fall <= 1'b0;
    end else begin
      low_run   <= sclk ? 16'd0 : ((low_run == 16'hFFFF) ? low_run : low_run + 16'd1);
      cs_run    <= cs_n ? 16'd0 : ((cs_run == 16'hFFFF) ? cs_run : cs_run + 16'd1);
      seen_fall <= cs_n ? 1'b0 : (seen_fall | !sclk);
    end
  end

  a_r10_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r2_low_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !$past(sclk)) |-> (low_run >= HALF16));

  a_r3_cs_setup_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(sclk) && !seen_fall) |-> (cs_run >= SETUP16));

  a_r7_read_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && is_rd) |-> !$past(drdy_s));

  a_r6_resync_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && is_rsync) |-> mosi);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  a_r8_done_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> is_rd);
endmodule

bind adc_spi_sequencer adc_spi_sequencer_chk #(
  .HALF_CYC     (HALF_CYC),
  .CS_SETUP_CYC (CS_SETUP_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .mosi      (mosi),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_done   (rd_done),
  .drdy_s    (drdy_s),
  .is_rd     (op_is_read),
  .is_rsync  (op_is_resync)
);

// File: tb/adc_spi_sequencer_tb_top.sv
module adc_spi_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int CSSU       = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic        req_chan = 1'b0;
  logic [7:0]  req_arg = 8'h00;
  logic        drdy_n = 1'b0;
  logic        miso;
  logic        sclk, mosi, cs_n;
  logic [15:0] rd_data;
  logic        rd_done;

  adc_spi_sequencer #(.HALF_CYC(HALF), .CS_SETUP_CYC(CSSU)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chan(req_chan), .req_arg(req_arg), .drdy_n(drdy_n),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .rd_data(rd_data),
    .rd_done(rd_done));

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // link monitor state
  logic [31:0] cap = '0;
  int nbits = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_done = 1'b0;
  int run = 0, setup_len = 0, setup_rec = 0;
  bit in_setup = 0;
  int min_low = 1000, min_high = 1000;
  int cs_fall_cnt = 0, done_cnt = 0, done_wide = 0;
  logic [15:0] done_data = '0;
  int cs_high_run = 0, min_gap = 1000, idle_sclk_err = 0;
  bit had_txn = 0;
  logic [23:0] slave = '0;

  assign miso = (nbits < 24) ? slave[23 - nbits] : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && !sclk) idle_sclk_err++;
      if (cs_n) cs_high_run++;
      if (prev_cs && !cs_n) begin
        cs_fall_cnt++;
        if (had_txn && cs_high_run < min_gap) min_gap = cs_high_run;
        had_txn = 1;
        cs_high_run = 0;
        nbits = 0; cap = '0; in_setup = 1; setup_len = 1; run = 1;
        min_low = 1000; min_high = 1000; done_cnt = 0; done_wide = 0;
      end else if (!cs_n) begin
        if (sclk != prev_sclk) begin
          if (in_setup) begin
            setup_rec = setup_len;
            in_setup = 0;
          end else if (!sclk) begin
            if (run < min_high) min_high = run;
          end else begin
            if (run < min_low) min_low = run;
          end
          if (sclk) begin
            cap = {cap[30:0], mosi};
            nbits++;
          end
          run = 1;
        end else begin
          run++;
          if (in_setup) setup_len++;
        end
      end
      if (rd_done) begin
        done_cnt++;
        done_data = rd_data;
        if (prev_done) done_wide++;
      end
      prev_cs = cs_n; prev_sclk = sclk; prev_done = rd_done;
    end
  end

  task automatic start_req(input logic [1:0] op, input logic ch, input logic [7:0] arg);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_chan = ch; req_arg = arg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic verify_txn(input logic [1:0] op, input logic ch, input logic [7:0] arg, input logic [15:0] sw);
    logic [31:0] exp_bits;
    int exp_len;
    logic [31:0] mask;
    string tag;
    case (op)
      2'd0: begin exp_bits = {16'h0, 8'h20 | {7'h0, ch}, arg}; exp_len = 16; tag = "R4"; end
      2'd1: begin exp_bits = {16'h0, 8'h10 | {7'h0, ch}, 1'b0, arg[6], arg[5:3], arg[2:0]}; exp_len = 16; tag = "R5"; end
      2'd2: begin exp_bits = 32'hFFFF_FFFF; exp_len = 32; tag = "R6"; end
      default: begin exp_bits = {8'h0, 8'h38 | {7'h0, ch}, 16'h0000}; exp_len = 24; tag = "R7"; end
    endcase
    mask = (exp_len == 32) ? 32'hFFFF_FFFF : ((32'd1 << exp_len) - 32'd1);
    check(nbits == exp_len, "R11 edge count", nbits, exp_len);
    check((cap & mask) == exp_bits, {tag, " serial frame"}, cap & mask, exp_bits);
    check(min_low == HALF, "R2 low phase", min_low, HALF);
    check(min_high == HALF, "R2 high phase", min_high, HALF);
    check(setup_rec >= CSSU, "R3 cs setup", setup_rec, CSSU);
    check(done_cnt == ((op == 2'd3) ? 1 : 0), "R8 done count", done_cnt, (op == 2'd3) ? 1 : 0);
    check(done_wide == 0, "R8 done width", done_wide, 0);
    if (op == 2'd3) check(done_data == sw, "R7 read data", done_data, sw);
  endtask

  task automatic run_txn(input logic [1:0] op, input logic ch, input logic [7:0] arg, input logic [15:0] sw);
    slave = {8'h00, sw};
    start_req(op, ch, arg);
    wait_idle();
    verify_txn(op, ch, arg, sw);
  endtask

  initial begin
    automatic logic [7:0] clk_args [5] = '{8'h05, 8'h0C, 8'h1F, 8'h00, 8'hA3};
    automatic logic [15:0] words [6] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h0000, 16'h3C5A};
    int falls0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    check(sclk == 1'b1, "R1 sclk in reset", sclk, 1);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(rd_done == 1'b0, "R1 done in reset", rd_done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b1 && req_ready == 1'b1, "R1 after reset",
          {cs_n, sclk, req_ready}, 3'b111);

    // R4 clock-register writes
    for (int ch = 0; ch < 2; ch++)
      for (int i = 0; i < 5; i++)
        run_txn(2'd0, ch[0], clk_args[i], 16'h0);

    // R5 setup writes: calibration, gain, flags, ignored top bit
    for (int ch = 0; ch < 2; ch++)
      for (int cal = 0; cal < 2; cal++)
        for (int g = 0; g < 8; g++)
          run_txn(2'd1, ch[0], {g[0], cal[0], g[2:0], g[2:0] ^ 3'b101}, 16'h0);

    // R6 resync burst
    run_txn(2'd2, 1'b0, 8'h00, 16'h0);
    run_txn(2'd2, 1'b1, 8'hFF, 16'h0);

    // R7 conversion reads
    for (int ch = 0; ch < 2; ch++)
      for (int i = 0; i < 6; i++)
        run_txn(2'd3, ch[0], 8'h00, words[i] ^ {15'h0, ch[0]});

    // R7 / R9: read held off by data-ready; busy requests dropped
    drdy_n = 1'b1;
    slave = {8'h00, 16'h5AA5};
    falls0 = cs_fall_cnt;
    start_req(2'd3, 1'b1, 8'h00);
    req_op = 2'd0; req_arg = 8'h77; req_valid = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
    end
    check(cs_fall_cnt == falls0, "R7 no cs before data-ready", cs_fall_cnt - falls0, 0);
    check(cs_n == 1'b1, "R7 cs held high", cs_n, 1);
    req_valid = 1'b0;
    req_op = 2'd3;
    drdy_n = 1'b0;
    wait_idle();
    verify_txn(2'd3, 1'b1, 8'h00, 16'h5AA5);
    repeat (60) @(negedge clk);
    check(cs_fall_cnt == falls0 + 1, "R9 busy request dropped", cs_fall_cnt - falls0, 1);

    // R10 gap and idle clock
    check(min_gap >= HALF, "R10 cs gap", min_gap, HALF);
    check(idle_sclk_err == 0, "R10 sclk high when deselected", idle_sclk_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule